// File: doc/BRIEF.md
# RMII Receive Dibit and Carrier/Valid Formatter

This block sits on the receive side of a 10/100 Ethernet physical layer. Upstream logic hands it received data one 4-bit nibble at a time, each with a write strobe and a data-valid flag. Alongside come a carrier-sense level and a flag that marks a false-carrier event. The block re-times the data onto a 50 MHz reference clock as a 2-bit data bus plus one combined carrier/valid line, which is the receive half of a reduced-pin MAC connection.

A nibble is sent as two dibits, the low-order pair first. A mode input picks the speed. At 100 Mb/s each dibit lasts one clock. At 10 Mb/s each dibit is held for a parameterised number of clocks, ten by default. A small nibble queue absorbs the rate change.

The combined line is high for every dibit slot that begins while carrier is present. If carrier drops while nibbles are still queued, the line alternates on each slot boundary, starting low, until the queue drains. The MAC can therefore tell carrier from data-valid. During a false carrier the data bus carries a fixed marker dibit.

Top module: `rmii_rx_fmt`

## Requirements
- R1: A low `rst_n` at a clock edge empties the nibble queue and drives `rxd` to 0 and `crs_dv` to 0 after that edge. No nibble accepted before the reset ever appears afterwards.
- R2: When idle (queue empty, `crs` low), `rxd` is 0 and `crs_dv` is 0. The first edge that samples `crs` high starts a slot at once and raises `crs_dv` after that edge.
- R3: Each queued nibble leaves as two consecutive dibits: bits [1:0] first, then bits [3:2], in the order the nibbles were accepted.
- R4: A slot lasts 1 clock when `fast_mode` is 1 and SLOW_HOLD clocks (default 10) when it is 0. `rxd` and `crs_dv` change only on slot boundaries.
- R5: A slot whose starting edge samples `crs` high has `crs_dv` = 1.
- R6: A slot that starts with `crs` low while the queue holds data has `crs_dv` inverted from the previous slot. The first such slot after carrier loss is therefore low, and the line then alternates once per slot (25 MHz at 100 Mb/s, 2.5 MHz at 10 Mb/s).
- R7: A slot that starts with the queue empty and `crs` low drives `crs_dv` = 0 and `rxd` = 0, ending the burst.
- R8: A slot that starts with the queue empty, `crs` high and `false_car` high outputs `rxd` = 2'b10 with `crs_dv` = 1.
- R9: A nibble is accepted only at an edge where both `nib_wr` and `rx_dv` are high. When FIFO_DEPTH (default 4) nibbles are queued, further nibbles are dropped.
- R10: A slot that starts with the queue empty, `crs` high and `false_car` low outputs `rxd` = 0 with `crs_dv` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_mode | input | 1 | 1 = 100 Mb/s (1-clock slots), 0 = 10 Mb/s (SLOW_HOLD-clock slots) |
| nib_wr | input | 1 | Write strobe for `nib_data` |
| nib_data | input | 4 | Received nibble |
| rx_dv | input | 1 | Received data valid; gates nibble acceptance |
| crs | input | 1 | Carrier sense level |
| false_car | input | 1 | False-carrier event flag |
| rxd | output | 2 | Receive dibit |
| crs_dv | output | 1 | Combined carrier sense / data valid |

## Verification
A slot counter that loses its phase shows up within one slot: `rxd` or `crs_dv` moves on a clock that is not a multiple of the slot length from the start of the burst. A queue pointer or pair-select fault swaps or repeats dibits, and the reassembled nibble is wrong within two slots of its acceptance. If the alternation state is wrong, the first slot after carrier loss comes out high instead of low. If the queue does not empty at the end, `crs_dv` stays up for one more slot, or data appears from an idle line after reset.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  localparam int NIB_W   = 4;
  localparam int DIBIT_W = 2;
  localparam int PAIRS   = NIB_W / DIBIT_W;
  localparam int SEL_W   = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  localparam logic [DIBIT_W-1:0] FALSE_CARRIER_DIBIT = 2'b10;

  // Clocks per dibit slot for the selected speed.
  function automatic int unsigned slot_cycles(input logic fast, input int unsigned slow_hold);
    return fast ? 1 : slow_hold;
  endfunction

  // Extract pair idx of a nibble, pair 0 being the low-order bits.
  function automatic logic [DIBIT_W-1:0] pick_pair(input logic [NIB_W-1:0] nib,
                                                   input logic [SEL_W-1:0] idx);
    logic [DIBIT_W-1:0] r;
    r = '0;
    for (int k = 0; k < PAIRS; k++) begin
      if (idx == SEL_W'(k)) r = nib[k*DIBIT_W +: DIBIT_W];
    end
    return r;
  endfunction

  function automatic logic [SEL_W-1:0] next_sel(input logic [SEL_W-1:0] sel);
    return (sel == SEL_W'(PAIRS-1)) ? '0 : sel + SEL_W'(1);
  endfunction
endpackage

// File: rtl/rmii_rx_nib_q.sv
module rmii_rx_nib_q #(
  parameter int DEPTH = 4,
  parameter int W     = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rmii_rx_slot_timer.sv
module rmii_rx_slot_timer
  import rmii_rx_pkg::*;
#(
  parameter int SLOW_HOLD = 10,
  localparam int CW       = (SLOW_HOLD > 1) ? $clog2(SLOW_HOLD) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  input  logic stay_busy,
  output logic tick
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;

  assign reload = CW'(slot_cycles(fast, SLOW_HOLD) - 1);
  assign tick   = (cnt == '0);

  // Idle slots reload zero so a new burst starts on the very next edge.
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= stay_busy ? reload : '0;
    else           cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/rmii_rx_fmt.sv
module rmii_rx_fmt
  import rmii_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int SLOW_HOLD  = 10,
  localparam int QCW       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fast_mode,
  input  logic       nib_wr,
  input  logic [3:0] nib_data,
  input  logic       rx_dv,
  input  logic       crs,
  input  logic       false_car,
  output logic [1:0] rxd,
  output logic       crs_dv
);
  // Named internal events, also observed by the bound checker.
  logic             slot_tick;
  logic             q_push_req;
  logic             q_pop;
  logic             q_empty;
  logic             q_full;
  logic [QCW-1:0]   q_count;
  logic [NIB_W-1:0] q_head;

  logic [SEL_W-1:0]   sel, sel_n;
  logic [DIBIT_W-1:0] rxd_n;
  logic               dv_n;
  logic               busy;
  logic               take;

  assign q_push_req = nib_wr && rx_dv;
  assign q_pop      = slot_tick && take;

  rmii_rx_nib_q #(.DEPTH(FIFO_DEPTH), .W(NIB_W)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push_req),
    .din   (nib_data),
    .pop   (q_pop),
    .dout  (q_head),
    .empty (q_empty),
    .full  (q_full),
    .count (q_count)
  );

  rmii_rx_slot_timer #(.SLOW_HOLD(SLOW_HOLD)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast      (fast_mode),
    .stay_busy (busy),
    .tick      (slot_tick)
  );

  // Content of the slot that starts at the next tick.
  always_comb begin
    rxd_n = '0;
    dv_n  = 1'b0;
    sel_n = sel;
    busy  = 1'b0;
    take  = 1'b0;
    if (!q_empty) begin
      rxd_n = pick_pair(q_head, sel);
      dv_n  = crs ? 1'b1 : ~crs_dv;
      sel_n = next_sel(sel);
      take  = (sel == SEL_W'(PAIRS-1));
      busy  = 1'b1;
    end else if (crs) begin
      rxd_n = false_car ? FALSE_CARRIER_DIBIT : '0;
      dv_n  = 1'b1;
      busy  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd    <= '0;
      crs_dv <= 1'b0;
      sel    <= '0;
    end else if (slot_tick) begin
      rxd    <= rxd_n;
      crs_dv <= dv_n;
      sel    <= sel_n;
    end
  end
endmodule

// File: rtl/rmii_rx_fmt_chk.sv
module rmii_rx_fmt_chk #(
  parameter int QCW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           crs,
  input logic           false_car,
  input logic           slot_tick,
  input logic           q_empty,
  input logic           q_full,
  input logic           q_push_req,
  input logic           q_pop,
  input logic [QCW-1:0] q_count,
  input logic [1:0]     rxd,
  input logic           crs_dv
);
  logic rst_d = 1'b1;
  always_ff @(posedge clk) rst_d <= rst_n;

  always @(posedge clk) begin
    if (!rst_d) begin
      AST_RST_QUIET: assert (crs_dv == 1'b0 && rxd == 2'b00); // R1
    end
  end

  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && !crs_dv && crs) |-> slot_tick); // R2

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> !q_empty); // R3

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> ($stable(rxd) && $stable(crs_dv))); // R4

  AST_CARRIER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && crs) |=> crs_dv); // R5

  AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && !crs && !q_empty) |=> (crs_dv != $past(crs_dv))); // R6

  AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && !crs && q_empty) |=> (!crs_dv && rxd == 2'b00)); // R7

  AST_FALSE_CAR: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && crs && false_car && q_empty) |=> (crs_dv && rxd == 2'b10)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push_req && q_full && !q_pop) |=> $stable(q_count)); // R9

  AST_CARRIER_IDLE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && crs && !false_car && q_empty) |=> (crs_dv && rxd == 2'b00)); // R10
endmodule

bind rmii_rx_fmt rmii_rx_fmt_chk #(.QCW(QCW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .crs        (crs),
  .false_car  (false_car),
  .slot_tick  (slot_tick),
  .q_empty    (q_empty),
  .q_full     (q_full),
  .q_push_req (q_push_req),
  .q_pop      (q_pop),
  .q_count    (q_count),
  .rxd        (rxd),
  .crs_dv     (crs_dv)
);

// File: tb/test_rmii_rx_fmt.sv
module test_rmii_rx_fmt;
  localparam int CLK_P    = 20;
  localparam int WDOG_CYC = 100000;
  localparam int HOLD10   = 10;

  logic       clk = 1'b0;
  logic       rst_n, fast_mode, nib_wr, rx_dv, crs, false_car;
  logic [3:0] nib_data;
  logic [1:0] rxd;
  logic       crs_dv;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  rmii_rx_fmt i_rmii_rx_fmt (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .nib_wr(nib_wr),
    .nib_data(nib_data), .rx_dv(rx_dv), .crs(crs), .false_car(false_car),
    .rxd(rxd), .crs_dv(crs_dv)
  );

  // Frame vectors: [11] fast, [10:8] nibble count, [7:4] seed, [3:0] slots with carrier low.
  localparam bit [11:0] FRAMES [6] = '{12'hC30, 12'hE91, 12'hBE2, 12'h250, 12'h3A3, 12'h1F1};

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic idle_in();
    nib_wr = 0; rx_dv = 0; crs = 0; false_car = 0; nib_data = 4'h0;
  endtask

  function automatic logic [3:0] nib_of(input int seed, input int i);
    return 4'((seed + 7*i) % 16);
  endfunction

  function automatic int outv();
    return int'({crs_dv, rxd});
  endfunction

  // Categories: 0 R2 start, 1 R3 data, 2 R4 hold, 3 R5 carrier high, 4 R6 toggle, 5 R7 end
  task automatic run_frame(input bit fast, input int n, input int seed, input int d, input int idx);
    int   lsl;
    int   last;
    int   bad [6];
    int   fa [6];
    int   fe [6];
    bit   seen [6];
    logic edv;
    logic [1:0] erxd;
    string tags [6];
    tags = '{"R2 burst start", "R3 dibit order", "R4 slot hold",
             "R5 carrier high", "R6 toggle", "R7 burst end"};
    lsl  = fast ? 1 : HOLD10;
    last = lsl * (2*n + 2);
    edv  = 0; erxd = 0;
    for (int c = 0; c < 6; c++) begin bad[c] = 0; fa[c] = 0; fe[c] = 0; seen[c] = 0; end
    fast_mode = fast;
    for (int e = 0; e <= last; e++) begin
      int  cr, cd;
      bit  crs_at;
      crs_at = (e <= lsl*(2*n - d));
      crs    = crs_at;
      rx_dv  = (e < 2*lsl*n);
      nib_wr = ((e % (2*lsl)) == 0) && ((e / (2*lsl)) < n);
      nib_data = nib_wr ? nib_of(seed, e / (2*lsl)) : 4'h0;
      step();
      if (e == 0) begin
        edv = 1; erxd = 0; cr = 0; cd = 0;
      end else if ((e % lsl) != 0) begin
        cr = 2; cd = 2;
      end else if ((e / lsl) <= 2*n) begin
        int j;
        logic [3:0] nb;
        j  = e / lsl;
        nb = nib_of(seed, (j-1)/2);
        erxd = ((j-1) % 2) ? nb[3:2] : nb[1:0];
        edv  = crs_at ? 1'b1 : ~edv;
        cr = 1; cd = crs_at ? 3 : 4;
      end else begin
        edv = 0; erxd = 0; cr = 5; cd = 5;
      end
      seen[cr] = 1; seen[cd] = 1;
      if (rxd != erxd) begin
        if (bad[cr] == 0) begin fa[cr] = outv(); fe[cr] = int'({edv, erxd}); end
        bad[cr]++;
      end
      if (crs_dv != edv) begin
        if (bad[cd] == 0) begin fa[cd] = outv(); fe[cd] = int'({edv, erxd}); end
        bad[cd]++;
      end
    end
    for (int c = 0; c < 6; c++) begin
      if (seen[c]) chk(bad[c] == 0, $sformatf("%s frame %0d", tags[c], idx), fa[c], fe[c]);
    end
    idle_in();
    repeat (3) step();
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", WDOG_CYC, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle_in();
    fast_mode = 1;
    rst_n = 0;
    step(); step();
    chk(outv() == 0, "R1 reset state", outv(), 0);
    rst_n = 1;
    step();
    chk(outv() == 0, "R2 idle with carrier low", outv(), 0);

    // Table-driven frames
    for (int f = 0; f < 6; f++) begin
      run_frame(FRAMES[f][11], int'(FRAMES[f][10:8]), int'(FRAMES[f][7:4]),
                int'(FRAMES[f][3:0]), f);
    end

    // R8 false carrier at 100 Mb/s
    fast_mode = 1; crs = 1; false_car = 1;
    for (int k = 0; k < 3; k++) begin
      step();
      chk(outv() == 3'b110, "R8 false carrier marker fast", outv(), 3'b110);
    end
    crs = 0; false_car = 0;
    step();
    chk(outv() == 0, "R7 end after false carrier fast", outv(), 0);
    repeat (2) step();

    // R8 false carrier at 10 Mb/s, carrier lost mid-slot
    fast_mode = 0; crs = 1; false_car = 1;
    for (int e = 0; e <= 20; e++) begin
      if (e == 12) begin crs = 0; false_car = 0; end
      step();
      if (e == 0)  chk(outv() == 3'b110, "R8 false carrier marker slow", outv(), 3'b110);
      if (e == 19) chk(outv() == 3'b110, "R4 hold until slot boundary", outv(), 3'b110);
      if (e == 20) chk(outv() == 0, "R7 end on slot boundary", outv(), 0);
    end
    idle_in();
    repeat (2) step();

    // R9 / R10: strobes without rx_dv are not accepted
    begin
      int bad_g;
      bad_g = 0;
      fast_mode = 1; crs = 1; rx_dv = 0; nib_data = 4'hF;
      for (int e = 0; e < 6; e++) begin
        nib_wr = ((e % 2) == 0);
        step();
        if (outv() != 3'b100) bad_g++;
      end
      chk(bad_g == 0, "R10 carrier without data gives zero dibits", bad_g, 0);
      idle_in();
      step();
      chk(outv() == 0, "R7 end with empty queue", outv(), 0);
      step();
      chk(outv() == 0, "R9 nibbles without rx_dv dropped", outv(), 0);
    end
    repeat (2) step();

    // R9 overflow and R6 long toggle at 10 Mb/s
    begin
      logic [3:0] ov [6];
      int bad_d, bad_v, fad, fed;
      ov = '{4'h1, 4'h6, 4'hB, 4'hC, 4'h3, 4'h9};
      bad_d = 0; bad_v = 0; fad = 0; fed = 0;
      fast_mode = 0;
      for (int e = 0; e <= 100; e++) begin
        crs    = (e < 5);
        rx_dv  = (e < 6);
        nib_wr = (e < 6);
        nib_data = (e < 6) ? ov[e] : 4'h0;
        step();
        if (e == 0) chk(outv() == 3'b100, "R2 burst start slow", outv(), 3'b100);
        if ((e % 10) == 0 && e >= 10 && e <= 80) begin
          int k;
          logic [3:0] nb;
          logic [1:0] ex;
          k  = e / 10;
          nb = ov[(k-1)/2];
          ex = ((k-1) % 2) ? nb[3:2] : nb[1:0];
          if (rxd != ex) begin if (bad_d == 0) begin fad = int'(rxd); fed = int'(ex); end bad_d++; end
          if (crs_dv != ((k % 2) == 0)) bad_v++;
        end
        if (e == 90)  chk(outv() == 0, "R7 end after drain", outv(), 0);
        if (e == 100) chk(outv() == 0, "R9 overflow nibbles dropped", outv(), 0);
      end
      chk(bad_d == 0, "R9 first four nibbles kept in order", fad, fed);
      chk(bad_v == 0, "R6 alternation at slow speed", bad_v, 0);
    end
    idle_in();
    repeat (2) step();

    // R1 reset in the middle of a burst
    begin
      int bad_r;
      bad_r = 0;
      fast_mode = 0; crs = 1; rx_dv = 1; nib_wr = 1; nib_data = 4'hA;
      step();
      nib_wr = 0;
      repeat (12) step();
      rst_n = 0; crs = 0; rx_dv = 0;
      step();
      chk(outv() == 0, "R1 outputs cleared by reset", outv(), 0);
      step();
      rst_n = 1;
      for (int e = 0; e < 40; e++) begin
        step();
        if (outv() != 0) bad_r++;
      end
      chk(bad_r == 0, "R1 queue emptied by reset", bad_r, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule